// File: doc/BRIEF.md
# Circular Column Shift Buffer

This block is an on-chip store of pixel data laid out as a grid of rows and columns. A stereo-matching engine reads it many times over, through two independent read ports. The buffer keeps a sliding window of image columns. The data are stored row by row, with addresses rising from low to high. Columns are never moved. A shift counter marks which physical column is the logical first (oldest) column. When a fresh image column comes in, it replaces that oldest column in every row, and the counter then steps one place to the right.

Readers give a logical row and a logical column. The block turns the logical column into a physical one by adding the shift counter modulo the column count. A column write is delivered as one element per cycle, from row 0 upwards, with a valid/ready handshake. After a column has been written, the port stays closed until the matching engine reports that every pixel of the current first column is finished. Fetching data from external memory is the job of a neighbouring block.

Top module: `csb_column_buffer`

## Requirements
- R1: In the cycle after reset is released, `shift_cnt` is 0, `col_wr_ready` is 1, and both `rd_valid_a` and `rd_valid_b` are 0.
- R2: A read request on either port raises that port's valid output in the following cycle, together with the stored pixel.
- R3: Logical column c is found at physical column (c + `shift_cnt`) mod COLS. After a column write, logical column COLS-1 returns the new column, and logical column 0 returns the column that followed the one just replaced.
- R4: A column write takes ROWS accepted beats. Beat k carries the pixel for row k. `shift_cnt` goes up by one on the edge that accepts the last beat.
- R5: `shift_cnt` goes from COLS-1 to 0.
- R6: Once a column write completes, `col_wr_ready` is 0. Beats offered while ready is 0 change neither the stored pixels nor `shift_cnt`.
- R7: A one-cycle `match_done` pulse while the port is closed sets `col_wr_ready` to 1 in the next cycle.
- R8: A read and a write to the same physical location in the same cycle return the data held before the write.
- R9: The two read ports work independently, and both can be used in the same cycle on different locations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| col_wr_valid | input | 1 | Column beat offered |
| col_wr_data | input | PIX_W | Pixel for the current row of the incoming column |
| col_wr_ready | output | 1 | Column port open |
| match_done | input | 1 | Pulse: matching of the current first column is finished |
| rd_en_a | input | 1 | Read request, port A |
| rd_row_a | input | ROW_W | Logical row, port A |
| rd_col_a | input | COL_W | Logical column, port A |
| rd_data_a | output | PIX_W | Read data, port A |
| rd_valid_a | output | 1 | Read data valid, port A |
| rd_en_b | input | 1 | Read request, port B |
| rd_row_b | input | ROW_W | Logical row, port B |
| rd_col_b | input | COL_W | Logical column, port B |
| rd_data_b | output | PIX_W | Read data, port B |
| rd_valid_b | output | 1 | Read data valid, port B |
| shift_cnt | output | COL_W | Physical index of logical column 0 |

## Verification
Read data is due exactly one edge after the request. The scoreboard pushes the expected pixel when it drives the request and pops it on the falling edge after the next rising edge, once `rd_valid` is seen. `shift_cnt` and `col_wr_ready` change on the edge that accepts the last beat, so the bench samples them at the falling edge that follows. The reopening of the port after `match_done` is sampled one falling edge after the pulse. The collision case issues the read in the same cycle as beat 0 of a column. It expects the pixel of the oldest column, because the bench model updates only after the whole column is in.

// File: rtl/csb_pkg.sv
package csb_pkg;

    localparam int unsigned DEF_ROWS  = 8;
    localparam int unsigned DEF_COLS  = 92;
    localparam int unsigned DEF_PIX_W = 8;
    localparam int unsigned NUM_RD    = 2;

    // state of the column-load gate
    typedef enum logic {
        GATE_HELD = 1'b0,
        GATE_OPEN = 1'b1
    } gate_e;

    // increment with wrap at lim
    function automatic int unsigned next_col(int unsigned c, int unsigned lim);
        return (c + 1 >= lim) ? 0 : c + 1;
    endfunction

endpackage

// File: rtl/csb_addr_map.sv
module csb_addr_map #(
    parameter int unsigned COLS  = csb_pkg::DEF_COLS,
    parameter int unsigned COL_W = $clog2(COLS)
) (
    input  logic [COL_W-1:0] log_col,
    input  logic [COL_W-1:0] origin,
    output logic [COL_W-1:0] phys_col
);
    localparam logic [COL_W:0] COLS_X = (COL_W+1)'(COLS);

    logic [COL_W:0] sum;

    always_comb begin
        sum = {1'b0, log_col} + {1'b0, origin};
        if (sum >= COLS_X) begin
            sum = sum - COLS_X;
        end
        phys_col = sum[COL_W-1:0];
    end
endmodule

// File: rtl/csb_wr_ctrl.sv
module csb_wr_ctrl
    import csb_pkg::*;
#(
    parameter int unsigned ROWS  = DEF_ROWS,
    parameter int unsigned COLS  = DEF_COLS,
    parameter int unsigned ROW_W = $clog2(ROWS),
    parameter int unsigned COL_W = $clog2(COLS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_valid,
    input  logic             match_done,
    output logic             wr_ready,
    output logic             wr_en,
    output logic [ROW_W-1:0] wr_row,
    output logic [COL_W-1:0] origin
);
    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);

    gate_e            gate_q;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] origin_q;
    logic             accept;

    assign accept   = wr_valid && (gate_q == GATE_OPEN);
    assign wr_ready = (gate_q == GATE_OPEN);
    assign wr_en    = accept;
    assign wr_row   = row_q;
    assign origin   = origin_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q   <= GATE_OPEN;
            row_q    <= '0;
            origin_q <= '0;
        end else if (accept) begin
            if (row_q == LAST_ROW) begin
                row_q    <= '0;
                origin_q <= COL_W'(next_col(32'(origin_q), COLS));
                gate_q   <= GATE_HELD;
            end else begin
                row_q <= row_q + 1'b1;
            end
        end else if (gate_q == GATE_HELD && match_done) begin
            gate_q <= GATE_OPEN;
        end
    end
endmodule

// File: rtl/csb_store.sv
module csb_store #(
    parameter int unsigned ROWS  = csb_pkg::DEF_ROWS,
    parameter int unsigned COLS  = csb_pkg::DEF_COLS,
    parameter int unsigned PIX_W = csb_pkg::DEF_PIX_W,
    parameter int unsigned NRD   = csb_pkg::NUM_RD,
    parameter int unsigned ROW_W = $clog2(ROWS),
    parameter int unsigned COL_W = $clog2(COLS)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [ROW_W-1:0]          wr_row,
    input  logic [COL_W-1:0]          wr_col,
    input  logic [PIX_W-1:0]          wr_data,
    input  logic [NRD-1:0]            rd_en,
    input  logic [NRD-1:0][ROW_W-1:0] rd_row,
    input  logic [NRD-1:0][COL_W-1:0] rd_col,
    output logic [NRD-1:0][PIX_W-1:0] rd_data,
    output logic [NRD-1:0]            rd_valid
);
    // row-major storage, low addresses first
    logic [PIX_W-1:0] mem [ROWS][COLS];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_row][wr_col] <= wr_data;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_ff @(posedge clk) begin
            if (rst) begin
                rd_data[p]  <= '0;
                rd_valid[p] <= 1'b0;
            end else begin
                rd_valid[p] <= rd_en[p];
                if (rd_en[p]) begin
                    rd_data[p] <= mem[rd_row[p]][rd_col[p]];
                end
            end
        end
    end
endmodule

// File: rtl/csb_column_buffer.sv
module csb_column_buffer #(
    parameter int unsigned ROWS  = csb_pkg::DEF_ROWS,
    parameter int unsigned COLS  = csb_pkg::DEF_COLS,
    parameter int unsigned PIX_W = csb_pkg::DEF_PIX_W,
    parameter int unsigned ROW_W = $clog2(ROWS),
    parameter int unsigned COL_W = $clog2(COLS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             col_wr_valid,
    input  logic [PIX_W-1:0] col_wr_data,
    output logic             col_wr_ready,
    input  logic             match_done,
    input  logic             rd_en_a,
    input  logic [ROW_W-1:0] rd_row_a,
    input  logic [COL_W-1:0] rd_col_a,
    output logic [PIX_W-1:0] rd_data_a,
    output logic             rd_valid_a,
    input  logic             rd_en_b,
    input  logic [ROW_W-1:0] rd_row_b,
    input  logic [COL_W-1:0] rd_col_b,
    output logic [PIX_W-1:0] rd_data_b,
    output logic             rd_valid_b,
    output logic [COL_W-1:0] shift_cnt
);
    localparam int unsigned NRD = csb_pkg::NUM_RD;

    logic                      wr_en;
    logic [ROW_W-1:0]          wr_row;
    logic [COL_W-1:0]          origin;
    logic [NRD-1:0]            rd_en;
    logic [NRD-1:0][ROW_W-1:0] rd_row;
    logic [NRD-1:0][COL_W-1:0] rd_lcol;
    logic [NRD-1:0][COL_W-1:0] rd_pcol;
    logic [NRD-1:0][PIX_W-1:0] rd_data;
    logic [NRD-1:0]            rd_valid;

    assign rd_en   = {rd_en_b, rd_en_a};
    assign rd_row  = {rd_row_b, rd_row_a};
    assign rd_lcol = {rd_col_b, rd_col_a};

    assign rd_data_a  = rd_data[0];
    assign rd_data_b  = rd_data[1];
    assign rd_valid_a = rd_valid[0];
    assign rd_valid_b = rd_valid[1];
    assign shift_cnt  = origin;

    csb_wr_ctrl #(
        .ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W), .COL_W(COL_W)
    ) wr_ctrl_i (
        .clk(clk), .rst(rst),
        .wr_valid(col_wr_valid), .match_done(match_done),
        .wr_ready(col_wr_ready), .wr_en(wr_en),
        .wr_row(wr_row), .origin(origin)
    );

    for (genvar p = 0; p < NRD; p++) begin : g_map
        csb_addr_map #(.COLS(COLS), .COL_W(COL_W)) map_i (
            .log_col(rd_lcol[p]), .origin(origin), .phys_col(rd_pcol[p])
        );
    end

    // the incoming column lands on the physical slot of logical column 0
    csb_store #(
        .ROWS(ROWS), .COLS(COLS), .PIX_W(PIX_W), .NRD(NRD),
        .ROW_W(ROW_W), .COL_W(COL_W)
    ) store_i (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_row(wr_row), .wr_col(origin), .wr_data(col_wr_data),
        .rd_en(rd_en), .rd_row(rd_row), .rd_col(rd_pcol),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );
endmodule

// File: rtl/csb_column_buffer_chk.sv
module csb_column_buffer_chk #(
    parameter int unsigned COLS  = csb_pkg::DEF_COLS,
    parameter int unsigned COL_W = $clog2(COLS)
) (
    input logic             clk,
    input logic             rst,
    input logic             rd_en_a,
    input logic             rd_valid_a,
    input logic             rd_en_b,
    input logic             rd_valid_b,
    input logic             col_wr_ready,
    input logic             match_done,
    input logic [COL_W-1:0] shift_cnt
);
    localparam logic [COL_W-1:0] TOP_COL = COL_W'(COLS - 1);

    // R2
    rd_lat_a_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en_a |=> rd_valid_a);

    // R2
    rd_lat_b_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en_b |=> rd_valid_b);

    // R4
    shift_step_chk: assert property (@(posedge clk) disable iff (rst)
        (shift_cnt != $past(shift_cnt)) |->
        (shift_cnt == (($past(shift_cnt) == TOP_COL) ? '0 : $past(shift_cnt) + 1'b1)));

    // R5
    shift_range_chk: assert property (@(posedge clk) disable iff (rst)
        shift_cnt <= TOP_COL);

    // R6
    held_no_shift_chk: assert property (@(posedge clk) disable iff (rst)
        !col_wr_ready |=> $stable(shift_cnt));

    // R6
    close_on_done_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(col_wr_ready) |-> (shift_cnt != $past(shift_cnt)));

    // R7
    reopen_chk: assert property (@(posedge clk) disable iff (rst)
        (match_done && !col_wr_ready) |=> col_wr_ready);
endmodule

bind csb_column_buffer csb_column_buffer_chk #(.COLS(COLS), .COL_W(COL_W)) chk_i (
    .clk(clk), .rst(rst),
    .rd_en_a(rd_en_a), .rd_valid_a(rd_valid_a),
    .rd_en_b(rd_en_b), .rd_valid_b(rd_valid_b),
    .col_wr_ready(col_wr_ready), .match_done(match_done),
    .shift_cnt(shift_cnt)
);

// File: tb/csb_column_buffer_tb_top.sv
module csb_column_buffer_tb_top;
    localparam int  NR = 4;
    localparam int  NC = 6;
    localparam int  PW = 8;
    localparam int  RW = $clog2(NR);
    localparam int  CW = $clog2(NC);
    localparam time CLK_PERIOD = 10ns;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          col_wr_valid = 1'b0;
    logic [PW-1:0] col_wr_data = '0;
    logic          col_wr_ready;
    logic          match_done = 1'b0;
    logic          rd_en_a = 1'b0, rd_en_b = 1'b0;
    logic [RW-1:0] rd_row_a = '0, rd_row_b = '0;
    logic [CW-1:0] rd_col_a = '0, rd_col_b = '0;
    logic [PW-1:0] rd_data_a, rd_data_b;
    logic          rd_valid_a, rd_valid_b;
    logic [CW-1:0] shift_cnt;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    int model [NR][NC];       // model[r][logical c]
    int q_a[$], q_b[$];
    string t_a[$], t_b[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    csb_column_buffer #(.ROWS(NR), .COLS(NC), .PIX_W(PW)) dut_i (
        .clk(clk), .rst(rst),
        .col_wr_valid(col_wr_valid), .col_wr_data(col_wr_data),
        .col_wr_ready(col_wr_ready), .match_done(match_done),
        .rd_en_a(rd_en_a), .rd_row_a(rd_row_a), .rd_col_a(rd_col_a),
        .rd_data_a(rd_data_a), .rd_valid_a(rd_valid_a),
        .rd_en_b(rd_en_b), .rd_row_b(rd_row_b), .rd_col_b(rd_col_b),
        .rd_data_b(rd_data_b), .rd_valid_b(rd_valid_b),
        .shift_cnt(shift_cnt)
    );

    function automatic int pix(int id, int r);
        return ((id * 16) + r) & 8'hFF;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 20000);
            finish_run();
        end
    end

    // monitor: pops expected read data
    always @(negedge clk) begin
        if (!rst && rd_valid_a) begin
            if (q_a.size() == 0) check(1'b0, "R2 port A spurious", 1, 0);
            else check(int'(rd_data_a) == q_a[0], t_a[0], int'(rd_data_a), q_a[0]);
            if (q_a.size() != 0) begin void'(q_a.pop_front()); void'(t_a.pop_front()); end
        end
        if (!rst && rd_valid_b) begin
            if (q_b.size() == 0) check(1'b0, "R9 port B spurious", 1, 0);
            else check(int'(rd_data_b) == q_b[0], t_b[0], int'(rd_data_b), q_b[0]);
            if (q_b.size() != 0) begin void'(q_b.pop_front()); void'(t_b.pop_front()); end
        end
    end

    // drive one cycle of reads; port enabled when row >= 0
    task automatic rd_cycle(int ra, int ca, int rb, int cb, string tag);
        @(negedge clk);
        rd_en_a = (ra >= 0);
        rd_en_b = (rb >= 0);
        if (ra >= 0) begin
            rd_row_a = RW'(ra); rd_col_a = CW'(ca);
            q_a.push_back(model[ra][ca]); t_a.push_back({tag, " port A"});
        end
        if (rb >= 0) begin
            rd_row_b = RW'(rb); rd_col_b = CW'(cb);
            q_b.push_back(model[rb][cb]); t_b.push_back({tag, " port B"});
        end
    endtask

    task automatic rd_idle();
        @(negedge clk);
        rd_en_a = 1'b0;
        rd_en_b = 1'b0;
    endtask

    // write a column; probe issues a colliding read on beat 0 (R8)
    task automatic wr_col(int id, bit probe);
        for (int r = 0; r < NR; r++) begin
            @(negedge clk);
            col_wr_valid = 1'b1;
            col_wr_data  = PW'(pix(id, r));
            rd_en_a = probe && (r == 0);
            if (probe && r == 0) begin
                rd_row_a = '0; rd_col_a = '0;
                q_a.push_back(model[0][0]); t_a.push_back("R8 collision");
            end
        end
        @(negedge clk);
        col_wr_valid = 1'b0;
        rd_en_a = 1'b0;
        for (int r = 0; r < NR; r++) begin
            for (int c = 0; c < NC - 1; c++) model[r][c] = model[r][c+1];
            model[r][NC-1] = pix(id, r);
        end
    endtask

    task automatic release_gate();
        @(negedge clk);
        match_done = 1'b1;
        @(negedge clk);
        match_done = 1'b0;
        check(col_wr_ready == 1'b1, "R7 reopen", int'(col_wr_ready), 1);
    endtask

    initial begin
        int exp_sh;
        for (int r = 0; r < NR; r++)
            for (int c = 0; c < NC; c++) model[r][c] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(shift_cnt == 0, "R1 shift", int'(shift_cnt), 0);
        check(col_wr_ready == 1'b1, "R1 ready", int'(col_wr_ready), 1);
        check(!rd_valid_a && !rd_valid_b, "R1 valid", int'(rd_valid_a | rd_valid_b), 0);

        // fill: R4 shift step, R5 wrap, R6 close
        exp_sh = 0;
        for (int id = 0; id < NC; id++) begin
            wr_col(id, 1'b0);
            exp_sh = (exp_sh + 1) % NC;
            check(int'(shift_cnt) == exp_sh, (id == NC-1) ? "R5 wrap" : "R4 shift",
                  int'(shift_cnt), exp_sh);
            check(col_wr_ready == 1'b0, "R6 closed", int'(col_wr_ready), 0);
            release_gate();
        end

        // R2/R3/R9: full sweep, port B walks in reverse
        for (int r = 0; r < NR; r++)
            for (int c = 0; c < NC; c++)
                rd_cycle(r, c, NR-1-r, NC-1-c, "R3 map");
        rd_idle();

        // R6: column 6, then offers while closed are ignored
        wr_col(6, 1'b0);
        check(col_wr_ready == 1'b0, "R6 closed", int'(col_wr_ready), 0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            col_wr_valid = 1'b1;
            col_wr_data  = 8'hEE;
        end
        @(negedge clk);
        col_wr_valid = 1'b0;
        check(int'(shift_cnt) == 1, "R6 shift held", int'(shift_cnt), 1);
        for (int r = 0; r < NR; r++) rd_cycle(r, NC-1, r, 0, "R6 data kept");
        rd_idle();

        // R8: read logical 0 of row 0 while beat 0 overwrites it
        release_gate();
        wr_col(7, 1'b1);
        rd_cycle(0, NC-1, 0, 0, "R3 after write");
        rd_idle();
        release_gate();

        // further columns across another wrap
        for (int id = 8; id < 8 + NC + 2; id++) begin
            wr_col(id, 1'b0);
            release_gate();
        end
        check(int'(shift_cnt) == (8 + NC + 2) % NC, "R5 second wrap",
              int'(shift_cnt), (8 + NC + 2) % NC);
        for (int r = 0; r < NR; r++)
            for (int c = 0; c < NC; c++)
                rd_cycle(r, c, r, (c + 3) % NC, "R9 dual");
        rd_idle();
        repeat (3) @(negedge clk);
        check(q_a.size() == 0 && q_b.size() == 0, "R2 drained",
              q_a.size() + q_b.size(), 0);
        finish_run();
    end
endmodule